// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a small byte-oriented CPU core and takes over the bus for the few cycles of an interrupt entry. It combines a vector of per-source request flags with a matching vector of per-source enables. A source counts as pending only when both bits are set. It then qualifies the result with the core's global mask bit and picks the pending source with the largest index. When the core strobes the end of an instruction, the sequencer captures the program counter, the index register, the accumulator and the condition code byte along with the stack pointer. It writes those five bytes one per cycle to a downward-growing stack. It then raises the mask and fetches a two-byte handler address from that source's vector slot.

The core holds off execution while `busy` is high. It loads the new program counter, the new mask and the final stack pointer in the cycle marked by `pc_load`. Memory reads have one cycle of latency: data for an address presented with `mem_re` arrives on `mem_rdata` in the following cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: A source is pending only when its request flag and its enable are both 1; with no source pending, an instruction-done strobe starts nothing and `busy` stays 0.
- R2: While `gmask_in` is 1, an instruction-done strobe starts nothing and `busy` stays 0.
- R3: Entry starts only on a cycle with `instr_done` high, `gmask_in` low and a pending source; `busy` is 1 from the next cycle for exactly 8 cycles.
- R4: Busy cycles 1 to 5 each perform one write (`mem_we`=1, `mem_re`=0) at addresses SP, SP-1, SP-2, SP-3, SP-4. SP is `sp_in` at the entry cycle. The data written, in that order, is PC bits 7:0, PC bits 15:8, X, A, CCR, all as sampled at the entry cycle.
- R5: In the `pc_load` cycle, `sp_out` equals the entry-cycle `sp_in` minus 5.
- R6: `gmask_out` is 1 during busy cycles 6 to 8 and follows `gmask_in` when idle.
- R7: The winning source is the pending source with the highest index, sampled at the clock edge that ends busy cycle 5, so a request that arrives during stacking can win. Changes in cycles 6 and later have no effect. If nothing is pending at that edge, the entry-time winner is kept.
- R8: The vector slot of source i starts at VEC_TOP - 2*i (VEC_TOP = 0xFFFE by default). Busy cycle 6 reads the slot address and cycle 7 reads slot+1, each with `mem_re`=1 and `mem_we`=0.
- R9: In busy cycle 8, `pc_load` is 1 and `pc_out` equals the byte read from the slot address in bits 15:8 and the byte read from slot+1 in bits 7:0.
- R10: After reset, `busy`, `mem_we`, `mem_re` and `pc_load` are 0.
- R11: `instr_done` during a busy sequence has no effect. After busy cycle 8, `busy` is 0 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | NSRC | Per-source request flags |
| irq_en | input | NSRC | Per-source enables |
| gmask_in | input | 1 | Current global interrupt mask |
| instr_done | input | 1 | Instruction boundary strobe |
| pc_in | input | 2*DW | Current program counter |
| x_in | input | DW | Index register value |
| a_in | input | DW | Accumulator value |
| ccr_in | input | DW | Condition code byte |
| sp_in | input | AW | Current stack pointer |
| mem_rdata | input | DW | Read data, one cycle after `mem_re` |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| gmask_out | output | 1 | New global mask |
| pc_out | output | 2*DW | Handler address, valid with `pc_load` |
| pc_load | output | 1 | One-cycle strobe: load PC, mask and SP |
| sp_out | output | AW | Stack pointer after stacking |
| busy | output | 1 | Entry sequence in progress |

## Verification
The internal state of this block is fully serialised onto the memory port, so a wrong step counter or state register appears within one cycle. It shows up as a strobe in the wrong cycle, a push address that does not step down by one, or a context byte in the wrong position. A wrong winner capture first shows at busy cycle 6 as a vector address off by a multiple of two. It then shows again two cycles later in `pc_out`. The random runs move late requests across the cycle-5 capture edge to separate capture timing errors from priority encoding errors.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PUSH = 3'd1,
      ST_RDH  = 3'd2,
      ST_RDL  = 3'd3,
      ST_LOAD = 3'd4
   } seq_st_t;

   localparam int unsigned PUSH_BYTES = 5;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned NSRC = 8,
   localparam int unsigned IW = $clog2(NSRC)
) (
   input  logic [NSRC-1:0] pend,
   output logic            any,
   output logic [IW-1:0]   idx
);
   generate
      if (NSRC < 2) begin : g_bad
         $error("irq_pick: NSRC must be at least 2");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (pend[i]) idx = IW'(i);
      end
   end

   assign any = |pend;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int unsigned    NSRC    = 8,
   parameter int unsigned    AW      = 16,
   parameter logic [AW-1:0]  VEC_TOP = 16'hFFFE,
   localparam int unsigned   IW      = $clog2(NSRC)
) (
   input  logic [IW-1:0] idx,
   input  logic          lo_sel,
   output logic [AW-1:0] addr
);
   generate
      if (AW < IW + 2) begin : g_bad_aw
         $error("irq_vec_addr: AW too narrow for the vector table");
      end
      if (int'(VEC_TOP) < 2 * (int'(NSRC) - 1)) begin : g_bad_top
         $error("irq_vec_addr: VEC_TOP below lowest slot");
      end
   endgenerate

   logic [AW-1:0] slot_off;
   assign slot_off = AW'(idx) << 1;
   assign addr     = VEC_TOP - slot_off + AW'(lo_sel);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int unsigned   NSRC    = 8,
   parameter int unsigned   DW      = 8,
   parameter int unsigned   AW      = 16,
   parameter logic [AW-1:0] VEC_TOP = 16'hFFFE,
   localparam int unsigned  IW      = $clog2(NSRC),
   localparam int unsigned  PW      = 2 * DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_flag,
   input  logic [NSRC-1:0] irq_en,
   input  logic            gmask_in,
   input  logic            instr_done,
   input  logic [PW-1:0]   pc_in,
   input  logic [DW-1:0]   x_in,
   input  logic [DW-1:0]   a_in,
   input  logic [DW-1:0]   ccr_in,
   input  logic [AW-1:0]   sp_in,
   input  logic [DW-1:0]   mem_rdata,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic            gmask_out,
   output logic [PW-1:0]   pc_out,
   output logic            pc_load,
   output logic [AW-1:0]   sp_out,
   output logic            busy
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("irq_entry_seq: DW must be positive");
      end
   endgenerate

   localparam logic [2:0] LAST_PUSH = 3'(PUSH_BYTES - 1);

   seq_st_t       st;
   logic [2:0]    cnt;
   logic [AW-1:0] sp_reg;
   logic [PW-1:0] ctx_pc;
   logic [DW-1:0] ctx_x, ctx_a, ctx_ccr;
   logic [IW-1:0] win_idx;
   logic [DW-1:0] hi_reg;
   logic          mask_set;

   logic [NSRC-1:0] pend;
   logic            pend_any;
   logic [IW-1:0]   pend_idx;
   logic            entry;
   logic [AW-1:0]   vaddr;

   assign pend = irq_flag & irq_en;

   irq_pick #(.NSRC(NSRC)) u_pick (
      .pend (pend),
      .any  (pend_any),
      .idx  (pend_idx)
   );

   irq_vec_addr #(.NSRC(NSRC), .AW(AW), .VEC_TOP(VEC_TOP)) u_vec (
      .idx    (win_idx),
      .lo_sel (st == ST_RDL),
      .addr   (vaddr)
   );

   assign entry = (st == ST_IDLE) && instr_done && !gmask_in && pend_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         sp_reg   <= '0;
         ctx_pc   <= '0;
         ctx_x    <= '0;
         ctx_a    <= '0;
         ctx_ccr  <= '0;
         win_idx  <= '0;
         hi_reg   <= '0;
         mask_set <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (entry) begin
                  st      <= ST_PUSH;
                  cnt     <= '0;
                  sp_reg  <= sp_in;
                  ctx_pc  <= pc_in;
                  ctx_x   <= x_in;
                  ctx_a   <= a_in;
                  ctx_ccr <= ccr_in;
                  win_idx <= pend_idx;
               end
            end
            ST_PUSH: begin
               sp_reg <= sp_reg - AW'(1);
               cnt    <= cnt + 3'd1;
               if (cnt == LAST_PUSH) begin
                  st       <= ST_RDH;
                  mask_set <= 1'b1;
                  if (pend_any) win_idx <= pend_idx;
               end
            end
            ST_RDH: st <= ST_RDL;
            ST_RDL: begin
               hi_reg <= mem_rdata;
               st     <= ST_LOAD;
            end
            ST_LOAD: begin
               st       <= ST_IDLE;
               mask_set <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (cnt)
         3'd0:    mem_wdata = ctx_pc[DW-1:0];
         3'd1:    mem_wdata = ctx_pc[PW-1:DW];
         3'd2:    mem_wdata = ctx_x;
         3'd3:    mem_wdata = ctx_a;
         default: mem_wdata = ctx_ccr;
      endcase
   end

   always_comb begin
      mem_addr = '0;
      if (st == ST_PUSH)                    mem_addr = sp_reg;
      else if (st == ST_RDH || st == ST_RDL) mem_addr = vaddr;
   end

   assign mem_we    = (st == ST_PUSH);
   assign mem_re    = (st == ST_RDH) || (st == ST_RDL);
   assign pc_load   = (st == ST_LOAD);
   assign busy      = (st != ST_IDLE);
   assign gmask_out = gmask_in | mask_set;
   assign pc_out    = {hi_reg, mem_rdata};
   assign sp_out    = sp_reg;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int unsigned NSRC = 8,
   parameter int unsigned AW   = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] irq_flag,
   input logic [NSRC-1:0] irq_en,
   input logic            gmask_in,
   input logic            instr_done,
   input logic [AW-1:0]   mem_addr,
   input logic            mem_we,
   input logic            mem_re,
   input logic            gmask_out,
   input logic            pc_load,
   input logic            busy
);
   p_no_entry_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(|(irq_flag & irq_en))) |=> !busy);

   p_no_entry_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && gmask_in) |=> !busy);

   p_entry_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && instr_done && !gmask_in && (|(irq_flag & irq_en))) |=> busy);

   p_rise_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(instr_done));

   p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

   p_mask_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> gmask_out);

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_load_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> ($past(mem_re) && busy));

   p_idle_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);
endmodule

bind irq_entry_seq irq_seq_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_flag   (irq_flag),
   .irq_en     (irq_en),
   .gmask_in   (gmask_in),
   .instr_done (instr_done),
   .mem_addr   (mem_addr),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .gmask_out  (gmask_out),
   .pc_load    (pc_load),
   .busy       (busy)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
   localparam int unsigned NSRC = 8;
   localparam int unsigned DW   = 8;
   localparam int unsigned AW   = 16;
   localparam logic [15:0] VTOP = 16'hFFFE;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] irq_flag = '0, irq_en = '0;
   logic            gmask_in = 1'b0, instr_done = 1'b0;
   logic [15:0]     pc_in = '0;
   logic [7:0]      x_in = '0, a_in = '0, ccr_in = '0;
   logic [15:0]     sp_in = '0;
   logic [7:0]      mem_rdata = '0;
   logic [15:0]     mem_addr;
   logic [7:0]      mem_wdata;
   logic            mem_we, mem_re, gmask_out, pc_load, busy;
   logic [15:0]     pc_out, sp_out;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_entry_seq #(.NSRC(NSRC), .DW(DW), .AW(AW), .VEC_TOP(VTOP)) u0 (.*);

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic int top_idx(input logic [NSRC-1:0] p);
      int r = -1;
      for (int i = 0; i < NSRC; i++) if (p[i]) r = i;
      return r;
   endfunction

   function automatic logic [15:0] slot(input int i);
      return VTOP - 16'(2 * i);
   endfunction

   always_ff @(posedge clk) if (mem_re) mem_rdata <= mem_byte(mem_addr);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // One entry; late_cyc (1..8, 0 = none) swaps the flags to late_f at that busy cycle.
   task automatic run_entry(input logic [NSRC-1:0] f, input logic [NSRC-1:0] en,
                            input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                            input logic [7:0] ccr, input logic [15:0] sp,
                            input logic [NSRC-1:0] late_f, input int late_cyc);
      logic [7:0] exp_w[5];
      int w0, wf;
      logic [15:0] va, exp_pc;
      irq_flag = f; irq_en = en; gmask_in = 1'b0;
      pc_in = pc; x_in = x; a_in = a; ccr_in = ccr; sp_in = sp;
      instr_done = 1'b1;
      exp_w[0] = pc[7:0]; exp_w[1] = pc[15:8]; exp_w[2] = x; exp_w[3] = a; exp_w[4] = ccr;
      w0 = top_idx(f & en);
      wf = w0;
      if (late_cyc >= 1 && late_cyc <= 5 && top_idx(late_f & en) >= 0) wf = top_idx(late_f & en);
      va = slot(wf);
      exp_pc = {mem_byte(va), mem_byte(va + 16'd1)};
      @(negedge clk);
      // instr_done held high: R11, must not restart mid-sequence
      pc_in = ~pc; x_in = ~x; a_in = ~a; ccr_in = ~ccr; sp_in = ~sp;
      for (int c = 1; c <= 8; c++) begin
         if (c == late_cyc) irq_flag = late_f;
         chk(busy === 1'b1, "R3 busy", 32'(busy), 1);
         if (c <= 5) begin
            chk(mem_we === 1'b1 && mem_re === 1'b0, "R4 write strobe", {mem_we, mem_re}, 2);
            chk(mem_addr === sp - 16'(c - 1), "R4 push addr", 32'(mem_addr), 32'(sp - 16'(c - 1)));
            chk(mem_wdata === exp_w[c-1], "R4 push data", 32'(mem_wdata), 32'(exp_w[c-1]));
         end else if (c <= 7) begin
            chk(mem_re === 1'b1 && mem_we === 1'b0, "R8 read strobe", {mem_we, mem_re}, 1);
            chk(mem_addr === va + 16'(c - 6), "R7 R8 vector addr", 32'(mem_addr), 32'(va + 16'(c - 6)));
            chk(gmask_out === 1'b1, "R6 mask set", 32'(gmask_out), 1);
         end else begin
            chk(pc_load === 1'b1, "R9 pc_load", 32'(pc_load), 1);
            chk(pc_out === exp_pc, "R9 pc_out", 32'(pc_out), 32'(exp_pc));
            chk(sp_out === sp - 16'd5, "R5 sp_out", 32'(sp_out), 32'(sp - 16'd5));
            chk(gmask_out === 1'b1, "R6 mask at load", 32'(gmask_out), 1);
         end
         @(negedge clk);
      end
      instr_done = 1'b0;
      chk(busy === 1'b0 && pc_load === 1'b0, "R11 idle gap", {busy, pc_load}, 0);
      chk(gmask_out === gmask_in, "R6 idle follow", 32'(gmask_out), 32'(gmask_in));
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      chk(busy === 0 && mem_we === 0 && mem_re === 0 && pc_load === 0, "R10 reset",
          {busy, mem_we, mem_re, pc_load}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R10 after release", 32'(busy), 0);

      // R1: flags without enables
      irq_flag = 8'hFF; irq_en = 8'h00; instr_done = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R1 no pending", 32'(busy), 0);
      // R2: masked
      irq_en = 8'hFF; gmask_in = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R2 masked", 32'(busy), 0);
      chk(gmask_out === 1'b1, "R6 idle follow high", 32'(gmask_out), 1);
      // R3: no strobe
      gmask_in = 1'b0; instr_done = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy === 1'b0, "R3 no strobe", 32'(busy), 0);

      // Directed: lowest and highest index, late arrival before/after capture
      run_entry(8'h01, 8'hFF, 16'h1234, 8'h56, 8'h78, 8'h9A, 16'h00FF, 8'h00, 0);
      run_entry(8'hFF, 8'hFF, 16'hBEEF, 8'h11, 8'h22, 8'h33, 16'h0100, 8'h00, 0);
      run_entry(8'h02, 8'hFF, 16'hCAFE, 8'h01, 8'h02, 8'h03, 16'h0004, 8'h80, 5); // R7 late wins
      run_entry(8'h02, 8'hFF, 16'hCAFE, 8'h01, 8'h02, 8'h03, 16'h0004, 8'h80, 6); // R7 too late
      run_entry(8'h10, 8'hFF, 16'h0000, 8'hFF, 8'h00, 8'hFF, 16'h0000, 8'h00, 3); // R7 vanished, keep
      run_entry(8'h30, 8'h10, 16'h4321, 8'hAA, 8'hBB, 8'hCC, 16'h8000, 8'h00, 0); // R1 enable gating

      for (int k = 0; k < 60; k++) begin
         logic [NSRC-1:0] f, en, lf;
         f  = 8'($urandom);
         en = 8'($urandom);
         if ((f & en) == 0) begin f[k % NSRC] = 1'b1; en[k % NSRC] = 1'b1; end
         lf = 8'($urandom);
         run_entry(f, en, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                   16'($urandom), lf, int'($urandom % 9));
      end
      summary();
   end
endmodule